// File: doc/BRIEF.md
# CRT raster timing generator

This block produces horizontal and vertical raster timing for a cathode-ray display. It counts character clocks across a scan line and scan lines down a frame. From fourteen byte-wide timing registers it derives a display-enable window, horizontal and vertical blanking, and horizontal and vertical retrace (sync) pulses. Each sync pulse can be inverted independently, and a read-only status byte reports the raw retrace state.

Software writes the registers through a simple index/data strobe. Each write lands in a staging copy. The whole staging copy moves into the active copy on the character clock that starts a new frame, so the counters never see a partly reprogrammed set. Counting advances only on cycles where `char_en` is high. Register values use offset encodings: line length minus five, vertical total minus two, and display ends minus one. Counts wider than eight bits take their high bits from a shared overflow register.

Top module: `crt_timing_gen`

## Requirements
- R1: A scan line lasts (reg0 + 5) character steps; the character index runs from 0 up to reg0 + 4 and then returns to 0.
- R2: `disp_en` is high exactly when the character index is at most reg1 and the line index is at most the 10-bit value {reg7[6], reg7[1], reg10}.
- R3: `hblank` turns on at the character whose index equals reg2. It turns off at the character whose low six index bits equal {reg5[7], reg3[4:0]}. If both match on the same character, turning on wins.
- R4: The horizontal retrace flag turns on at the character index equal to reg4 and turns off where the low five index bits equal reg5[4:0]. Turning on wins if both match.
- R5: A frame holds {reg7[5], reg7[0], reg6} + 2 lines. The line index advances only when the character index wraps.
- R6: The vertical retrace flag turns on at line {reg7[7], reg7[2], reg8} and turns off at the line whose low four bits equal reg9[3:0]. `vblank` turns on at line {reg7[3], reg11} and turns off at the line whose low eight bits equal reg12. Both change only at character index 0.
- R7: reg13 bit 6 inverts `hsync` and bit 7 inverts `vsync`; 0 gives active-high pulses and 1 gives active-low. By convention the pair {bit7, bit6} announces 400 lines as 01, 350 lines as 10 and 480 lines as 11.
- R8: `status` bit 3 equals the raw vertical retrace flag and bit 0 equals the raw horizontal retrace flag, whatever the polarity; all other status bits are 0.
- R9: A register write changes no output timing until the first character of the next frame. From that character on, all registers written before it apply together.
- R10: While `char_en` is low, the counters, the flags and every output hold their values.
- R11: While `rst_n` is low, `hsync` and `vsync` are 0. A synchronous reset returns both counters to 0, clears every flag, and loads both register copies with reg0..reg13 = 3,4,5,0,6,7,4,0,4,5,3,4,0,0.
- R12: Writes to index 14 or 15 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| char_en | input | 1 | Character-clock enable; one count step per high cycle |
| reg_we | input | 1 | Register write strobe |
| reg_idx | input | 4 | Register index 0..13 |
| reg_wdata | input | 8 | Register write data |
| disp_en | output | 1 | Active display window |
| hblank | output | 1 | Horizontal blanking |
| vblank | output | 1 | Vertical blanking |
| hsync | output | 1 | Horizontal sync after polarity |
| vsync | output | 1 | Vertical sync after polarity |
| status | output | 8 | Retrace status byte |

## Verification
The embedded properties assume that reset is held across at least one clock edge before release. They also assume the line length never falls below five characters, which the offset encoding guarantees. The flag behaviour is only meaningful when each programmed start and end point falls inside the line or frame. The stimulus uses three hand-built configurations whose start and end points all lie inside their ranges. Every configuration write starts right after a frame boundary and completes well before the next one, so no staging set is split across a frame start.

// File: rtl/crt_timing_gen.sv
module crt_timing_gen #(
  parameter int HCW = 9,
  parameter int VCW = 10
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       char_en,
  input  logic       reg_we,
  input  logic [3:0] reg_idx,
  input  logic [7:0] reg_wdata,
  output logic       disp_en,
  output logic       hblank,
  output logic       vblank,
  output logic       hsync,
  output logic       vsync,
  output logic [7:0] status
);
  localparam int NREG = 14;
  localparam logic [NREG-1:0][7:0] RST_VAL = {8'd0, 8'd0, 8'd4, 8'd3, 8'd5, 8'd4, 8'd0,
                                              8'd4, 8'd7, 8'd6, 8'd0, 8'd5, 8'd4, 8'd3};

  logic [NREG-1:0][7:0] stage_q, act_q;
  logic [HCW-1:0] hcnt, hnext, ht_last, hde, hbs, hss;
  logic [VCW-1:0] vcnt, vnext, vt_last, vde, vbs, vss;
  logic [7:0] ovf, vbe;
  logic [5:0] hbe;
  logic [4:0] hse;
  logic [3:0] vse;
  logic hb_q, hs_q, vb_q, vs_q, line_end, frame_end;
  logic unused_bits;

  assign ovf     = act_q[7];
  assign ht_last = HCW'(act_q[0]) + HCW'(4);
  assign hde     = HCW'(act_q[1]);
  assign hbs     = HCW'(act_q[2]);
  assign hbe     = {act_q[5][7], act_q[3][4:0]};
  assign hss     = HCW'(act_q[4]);
  assign hse     = act_q[5][4:0];
  assign vt_last = VCW'({ovf[5], ovf[0], act_q[6]}) + VCW'(1);
  assign vde     = VCW'({ovf[6], ovf[1], act_q[10]});
  assign vss     = VCW'({ovf[7], ovf[2], act_q[8]});
  assign vse     = act_q[9][3:0];
  assign vbs     = VCW'({ovf[3], act_q[11]});
  assign vbe     = act_q[12];
  assign unused_bits = ^{act_q[3][7:5], act_q[5][6:5], ovf[4], act_q[9][7:4], act_q[13][5:0]};

  assign line_end  = hcnt == ht_last;
  assign frame_end = line_end && (vcnt == vt_last);
  assign hnext     = line_end ? '0 : hcnt + HCW'(1);
  assign vnext     = !line_end ? vcnt : (frame_end ? '0 : vcnt + VCW'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hcnt    <= '0;
      vcnt    <= '0;
      hb_q    <= 1'b0;
      hs_q    <= 1'b0;
      vb_q    <= 1'b0;
      vs_q    <= 1'b0;
      stage_q <= RST_VAL;
      act_q   <= RST_VAL;
    end else begin
      if (reg_we && reg_idx < 4'(NREG)) stage_q[reg_idx] <= reg_wdata;
      if (char_en) begin
        hcnt <= hnext;
        vcnt <= vnext;
        if (hnext == hbs) hb_q <= 1'b1;
        else if (hnext[5:0] == hbe) hb_q <= 1'b0;
        if (hnext == hss) hs_q <= 1'b1;
        else if (hnext[4:0] == hse) hs_q <= 1'b0;
        if (line_end) begin
          if (vnext == vbs) vb_q <= 1'b1;
          else if (vnext[7:0] == vbe) vb_q <= 1'b0;
          if (vnext == vss) vs_q <= 1'b1;
          else if (vnext[3:0] == vse) vs_q <= 1'b0;
        end
        if (frame_end) act_q <= stage_q;
      end
    end
  end

  assign disp_en = (hcnt <= hde) && (vcnt <= vde);
  assign hblank  = hb_q;
  assign vblank  = vb_q;
  assign hsync   = rst_n & (hs_q ^ act_q[13][6]);
  assign vsync   = rst_n & (vs_q ^ act_q[13][7]);
  assign status  = {4'b0000, vs_q, 2'b00, hs_q};

  AST_HCNT_IN_LINE: assert property (@(posedge clk) disable iff (!rst_n)
    hcnt <= ht_last); // R1
  AST_LINE_STEP_AT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (vcnt != $past(vcnt)) |-> $past(line_end && char_en)); // R5
  AST_VFLAGS_AT_LINE_START: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(vb_q) || !$stable(vs_q)) |-> (hcnt == '0)); // R6
  AST_ACTIVE_ONLY_AT_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(frame_end && char_en) |-> $stable(act_q)); // R9
  AST_HOLD_WITHOUT_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(char_en) |-> ($stable(hcnt) && $stable(vcnt) && $stable(hs_q) && $stable(vs_q))); // R10
  AST_HRETRACE_ON_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hs_q) |-> $past(char_en)); // R4
endmodule

// File: tb/test_crt_timing_gen.sv
module test_crt_timing_gen;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n, char_en, reg_we;
  logic [3:0] reg_idx;
  logic [7:0] reg_wdata;
  logic disp_en, hblank, vblank, hsync, vsync;
  logic [7:0] status;

  crt_timing_gen i_crt_timing_gen (
    .clk(clk), .rst_n(rst_n), .char_en(char_en), .reg_we(reg_we),
    .reg_idx(reg_idx), .reg_wdata(reg_wdata), .disp_en(disp_en),
    .hblank(hblank), .vblank(vblank), .hsync(hsync), .vsync(vsync), .status(status)
  );

  localparam logic [7:0] DEF [14] = '{3, 4, 5, 0, 6, 7, 4, 0, 4, 5, 3, 4, 0, 0};
  localparam logic [7:0] CFG_B [14] = '{1, 2, 3, 5, 4, 5, 1, 0, 2, 0, 0, 1, 0, 8'hC0};
  localparam logic [7:0] CFG_C [14] = '{1, 2, 3, 5, 4, 5, 8'h2C, 8'h0F, 8'h2C, 13, 0, 1, 0, 0};
  // {position since reset, disp, hblank, hsync, vblank, vsync} for the reset-value frame
  localparam logic [12:0] TAB [12] = '{
    {8'd0,  5'b10000}, {8'd4,  5'b10000}, {8'd5,  5'b01000}, {8'd6,  5'b01100},
    {8'd7,  5'b01000}, {8'd8,  5'b10000}, {8'd31, 5'b01000}, {8'd32, 5'b00011},
    {8'd38, 5'b01111}, {8'd40, 5'b00010}, {8'd45, 5'b01010}, {8'd47, 5'b01010}};

  int checks = 0, errors = 0;
  bit done = 0;
  logic [7:0] sreg [14];
  logic [7:0] areg [14];
  int mh, mv, since_rst;
  bit mhb, mhs, mvb, mvs;

  function automatic int f_ht();  return int'(areg[0]) + 5; endfunction
  function automatic int f_vt();  return int'({areg[7][5], areg[7][0], areg[6]}) + 2; endfunction
  function automatic int f_hde(); return int'(areg[1]); endfunction
  function automatic int f_vde(); return int'({areg[7][6], areg[7][1], areg[10]}); endfunction

  always @(posedge clk) begin
    int nh, nv;
    bit le, fe;
    if (rst_n) begin
      if (char_en) begin
        le = (mh == f_ht() - 1);
        fe = le && (mv == f_vt() - 1);
        nh = le ? 0 : mh + 1;
        nv = le ? (fe ? 0 : mv + 1) : mv;
        if (nh == int'(areg[2])) mhb = 1;
        else if (nh % 64 == int'({areg[5][7], areg[3][4:0]})) mhb = 0;
        if (nh == int'(areg[4])) mhs = 1;
        else if (nh % 32 == int'(areg[5][4:0])) mhs = 0;
        if (le) begin
          if (nv == int'({areg[7][3], areg[11]})) mvb = 1;
          else if (nv % 256 == int'(areg[12])) mvb = 0;
          if (nv == int'({areg[7][7], areg[7][2], areg[8]})) mvs = 1;
          else if (nv % 16 == int'(areg[9][3:0])) mvs = 0;
        end
        mh = nh;
        mv = nv;
        since_rst++;
        if (fe) foreach (areg[i]) areg[i] = sreg[i];
      end
      if (reg_we && reg_idx < 4'd14) sreg[reg_idx] = reg_wdata;
    end
  end

  task automatic chk(string rq, string what, int got, int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s %s: got %0d expected %0d", rq, what, got, exp);
    end
  endtask

  task automatic check_now(string ctx);
    chk("R2", {ctx, " disp_en"}, int'(disp_en), int'(mh <= f_hde() && mv <= f_vde()));
    chk("R3", {ctx, " hblank"}, int'(hblank), int'(mhb));
    chk("R4 R7", {ctx, " hsync"}, int'(hsync), int'(mhs ^ areg[13][6]));
    chk("R6", {ctx, " vblank"}, int'(vblank), int'(mvb));
    chk("R6 R7", {ctx, " vsync"}, int'(vsync), int'(mvs ^ areg[13][7]));
    chk("R8", {ctx, " status"}, int'(status), int'({4'b0, mvs, 2'b0, mhs}));
  endtask

  task automatic run(int n, string ctx);
    repeat (n) begin
      check_now(ctx);
      @(negedge clk);
    end
  endtask

  task automatic to_frame_start(string ctx);
    while (!(mh == 0 && mv == 0)) run(1, ctx);
  endtask

  task automatic wr(int idx, int data, string ctx);
    reg_we = 1'b1;
    reg_idx = 4'(idx);
    reg_wdata = 8'(data);
    check_now(ctx);
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk("R11", "hsync in reset", int'(hsync), 0);
    chk("R11", "vsync in reset", int'(vsync), 0);
    repeat (3) @(negedge clk);
    chk("R11", "status after reset", int'(status), 0);
    chk("R11", "hblank after reset", int'(hblank), 0);
    chk("R11", "vblank after reset", int'(vblank), 0);
    chk("R11", "disp_en after reset", int'(disp_en), 1);
    foreach (DEF[i]) begin sreg[i] = DEF[i]; areg[i] = DEF[i]; end
    mh = 0; mv = 0; since_rst = 0;
    mhb = 0; mhs = 0; mvb = 0; mvs = 0;
    rst_n = 1'b1;
  endtask

  task automatic measure(int sel, int exp, string rq);
    int n;
    bit prev, cur;
    prev = status[sel];
    @(negedge clk);
    cur = status[sel];
    while (!(cur && !prev)) begin prev = cur; @(negedge clk); cur = status[sel]; end
    n = 0;
    do begin prev = cur; @(negedge clk); cur = status[sel]; n++; end while (!(cur && !prev));
    chk(rq, "retrace period", n, exp);
  endtask

  initial begin
    rst_n = 1'b0; char_en = 1'b1; reg_we = 1'b0; reg_idx = '0; reg_wdata = '0;
    do_reset();

    foreach (TAB[k]) begin
      while (since_rst < int'(TAB[k][12:5])) run(1, "R1 table");
      chk("R2", "table disp_en", int'(disp_en), int'(TAB[k][4]));
      chk("R3", "table hblank", int'(hblank), int'(TAB[k][3]));
      chk("R4", "table hsync", int'(hsync), int'(TAB[k][2]));
      chk("R6", "table vblank", int'(vblank), int'(TAB[k][1]));
      chk("R6", "table vsync", int'(vsync), int'(TAB[k][0]));
    end
    run(1, "R1 wrap");
    measure(0, 8, "R1");
    measure(3, 48, "R5");

    while (mh != 5) run(1, "R10 lead");
    char_en = 1'b0;
    run(5, "R10 held");
    char_en = 1'b1;
    run(3, "R10 resumed");

    to_frame_start("R12 lead");
    wr(14, 8'hFF, "R12");
    wr(15, 8'h00, "R12");
    run(1, "R12");
    to_frame_start("R12");
    run(48, "R12 frame after ignored writes");

    to_frame_start("R9 lead");
    for (int i = 0; i < 14; i++) wr(i, CFG_B[i], "R9 staged");
    to_frame_start("R9 old frame");
    chk("R9", "new line length in use", f_ht(), 6);
    run(18, "R9 R7 B frame");
    measure(0, 6, "R1");
    while (!(mv == 0 && mh == 0)) run(1, "R7 lead");
    chk("R7", "idle active-low hsync", int'(hsync), 1);
    chk("R7", "idle active-low vsync", int'(vsync), 1);

    do_reset();
    for (int i = 0; i < 14; i++) wr(i, CFG_C[i], "R9 staged C");
    to_frame_start("R9 old frame");
    run(1812, "R5 C frame");
    measure(3, 1812, "R5");

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got hang expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule